// File: doc/BRIEF.md
# Process-Tagged Fully Associative Translation Buffer

This block caches recent virtual-to-physical page translations for a processor pipeline. Every entry carries an address-space identifier next to its virtual page number. Translations from several processes can therefore stay resident together, and a context switch does not require emptying the buffer. A lookup presents a process identifier and a full virtual address. In the same cycle the block answers with a hit flag, the physical address, the page's dirty bit and its access-rights field. Pages are 8 KB, so the low 13 address bits pass through untouched.

When a lookup misses, an external page walker installs the translation through the refill port. The block chooses the slot itself and shows that choice on `victim_idx`. An empty slot is always taken first. Once the buffer is full, the slot comes from a free-running LFSR, steered away from the entry touched most recently. Software or the pipeline can drop every entry in one cycle. It can also drop only the entries that belong to one process.

The entry count must be a power of two. Use 32 for a data-side buffer and 8 for an instruction-side buffer.

Top module: `tlb_pid`

## Requirements
- R1: After reset every entry is invalid, every lookup misses, and `victim_idx` is 0.
- R2: A lookup hits only when an entry is valid and matches both the process ID and the virtual page number (address bits 42..13). The hit flag, physical address, dirty bit and rights are valid in the same cycle the lookup is presented.
- R3: An entry with a matching page number but a different process ID does not hit. Two processes can each hold their own translation for the same page number.
- R4: On a hit, the physical address is the stored 21-bit physical page number placed above the unchanged 13-bit page offset of the lookup address.
- R5: While any entry is invalid, a refill writes the lowest-numbered invalid entry, and `victim_idx` shows that index beforehand.
- R6: While all entries are valid, `victim_idx` never equals the most recently used entry. The most recently used entry is the one that last hit a lookup or last received a refill. A refill wins when both happen in the same cycle.
- R7: A full flush invalidates every entry in one cycle. A refill presented in the same cycle is discarded.
- R8: A flush by process ID invalidates exactly the entries tagged with that ID. All other entries keep hitting.
- R9: A refill presented in the same cycle as a flush by process ID is installed and survives, even when its process ID equals the flushed one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_pid | input | PID_W | Process ID of the lookup |
| lk_va | input | VA_W | Virtual address to translate |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | PA_W | Translated physical address |
| lk_dirty | output | 1 | Dirty bit of the hit entry |
| lk_rights | output | RIGHTS_W | Access rights of the hit entry |
| rf_valid | input | 1 | Refill write request |
| rf_pid | input | PID_W | Process ID of the new entry |
| rf_vpn | input | VPN_W | Virtual page number of the new entry |
| rf_ppn | input | PPN_W | Physical page number of the new entry |
| rf_dirty | input | 1 | Dirty bit of the new entry |
| rf_rights | input | RIGHTS_W | Access rights of the new entry |
| flush_all | input | 1 | Invalidate every entry |
| flush_pid_en | input | 1 | Invalidate the entries of one process |
| flush_pid | input | PID_W | Process ID to invalidate |
| victim_idx | output | IDX_W | Slot the next refill will write |

## Verification
Some properties are checked on every cycle. When the buffer is full, the victim never points at the most recently used slot. An invalid slot is always preferred. A refill lands in the announced slot with the given tags. A full flush leaves nothing valid. The most-recently-used pointer follows a hit. No lookup ever matches two entries.

Other behaviours only show up in the bench's scenarios. These are the exact physical address, dirty bit and rights returned. The isolation between processes that share a page number also needs a scenario. So does the selective flush, which must leave the other processes intact. Finally, the refill that survives a same-cycle flush of its own process can only be shown this way.

// File: rtl/tlb_pid.sv
module tlb_pid #(
  parameter int ENTRIES   = 32,
  parameter int VA_W      = 43,
  parameter int PA_W      = 34,
  parameter int OFF_W     = 13,
  parameter int PID_W     = 8,
  parameter int RIGHTS_W  = 2,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  localparam int VPN_W    = VA_W - OFF_W,
  localparam int PPN_W    = PA_W - OFF_W,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lk_valid,
  input  logic [PID_W-1:0]    lk_pid,
  input  logic [VA_W-1:0]     lk_va,
  output logic                lk_hit,
  output logic [PA_W-1:0]     lk_pa,
  output logic                lk_dirty,
  output logic [RIGHTS_W-1:0] lk_rights,
  input  logic                rf_valid,
  input  logic [PID_W-1:0]    rf_pid,
  input  logic [VPN_W-1:0]    rf_vpn,
  input  logic [PPN_W-1:0]    rf_ppn,
  input  logic                rf_dirty,
  input  logic [RIGHTS_W-1:0] rf_rights,
  input  logic                flush_all,
  input  logic                flush_pid_en,
  input  logic [PID_W-1:0]    flush_pid,
  output logic [IDX_W-1:0]    victim_idx
);

  logic [ENTRIES-1:0]  v;
  logic [PID_W-1:0]    e_pid    [ENTRIES];
  logic [VPN_W-1:0]    e_vpn    [ENTRIES];
  logic [PPN_W-1:0]    e_ppn    [ENTRIES];
  logic                e_dirty  [ENTRIES];
  logic [RIGHTS_W-1:0] e_rights [ENTRIES];

  logic [IDX_W-1:0] mru;
  logic [15:0]      lfsr;
  logic [ENTRIES-1:0] match, kill;
  logic [IDX_W-1:0] hit_idx, first_inv, rnd;
  logic             any_inv, install;

  wire [VPN_W-1:0] lk_vpn = lk_va[VA_W-1:OFF_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = v[g] && e_pid[g] == lk_pid && e_vpn[g] == lk_vpn;
    assign kill[g]  = flush_pid_en && e_pid[g] == flush_pid;
  end

  always_comb begin
    hit_idx   = '0;
    first_inv = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
      if (!v[i])    first_inv = IDX_W'(i);
    end
  end

  assign any_inv    = ~&v;
  assign rnd        = lfsr[IDX_W-1:0];
  assign victim_idx = any_inv ? first_inv : (rnd == mru ? rnd + 1'b1 : rnd);
  assign install    = rf_valid && !flush_all;

  assign lk_hit    = lk_valid && |match;
  assign lk_pa     = {e_ppn[hit_idx], lk_va[OFF_W-1:0]};
  assign lk_dirty  = e_dirty[hit_idx];
  assign lk_rights = e_rights[hit_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v    <= '0;
      mru  <= '0;
      lfsr <= LFSR_SEED;
    end else begin
      lfsr <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
      if (flush_all) v <= '0;
      else begin
        v <= v & ~kill;
        if (rf_valid) v[victim_idx] <= 1'b1;
      end
      if (install)     mru <= victim_idx;
      else if (lk_hit) mru <= hit_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (install) begin
      e_pid[victim_idx]    <= rf_pid;
      e_vpn[victim_idx]    <= rf_vpn;
      e_ppn[victim_idx]    <= rf_ppn;
      e_dirty[victim_idx]  <= rf_dirty;
      e_rights[victim_idx] <= rf_rights;
    end
  end

  a_r6_victim_not_mru: assert property (@(posedge clk) disable iff (!rst_n)
    (&v) |-> victim_idx != mru);

  a_r5_invalid_first: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_valid && any_inv) |-> !v[victim_idx]);

  a_r5_refill_lands: assert property (@(posedge clk) disable iff (!rst_n)
    install |=> v[$past(victim_idx)] && e_vpn[$past(victim_idx)] == $past(rf_vpn)
                && e_pid[$past(victim_idx)] == $past(rf_pid));

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> v == '0);

  a_r6_mru_tracks_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && !rf_valid) |=> mru == $past(hit_idx));

  a_r2_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

endmodule

// File: tb/tlb_pid_tb.sv
module tlb_pid_tb;
  localparam int N = 32;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic        lk_valid = 0, rf_valid = 0, rf_dirty = 0, flush_all = 0, flush_pid_en = 0;
  logic [7:0]  lk_pid = 0, rf_pid = 0, flush_pid = 0;
  logic [42:0] lk_va = 0;
  logic [29:0] rf_vpn = 0;
  logic [20:0] rf_ppn = 0;
  logic [1:0]  rf_rights = 0, lk_rights;
  logic        lk_hit, lk_dirty;
  logic [33:0] lk_pa;
  logic [4:0]  victim_idx;

  tlb_pid u_dut (.clk, .rst_n, .lk_valid, .lk_pid, .lk_va, .lk_hit, .lk_pa, .lk_dirty,
    .lk_rights, .rf_valid, .rf_pid, .rf_vpn, .rf_ppn, .rf_dirty, .rf_rights,
    .flush_all, .flush_pid_en, .flush_pid, .victim_idx);

  typedef struct {
    int kind;
    string req;
    logic hit; logic [33:0] pa; logic d; logic [1:0] r;
    int idx;
  } exp_t;
  exp_t q[$];
  int compared = 0, mismatched = 0;

  bit         mv [N];
  logic [7:0] mpid [N];
  logic [29:0] mvpn [N];
  logic [20:0] mppn [N];
  logic       md [N];
  logic [1:0] mr [N];
  int mmru = 0;

  function automatic int low_inv();
    for (int i = 0; i < N; i++) if (!mv[i]) return i;
    return -1;
  endfunction

  task automatic clr();
    lk_valid = 0; rf_valid = 0; flush_all = 0; flush_pid_en = 0;
  endtask

  task automatic look(input logic [7:0] pid, input logic [29:0] vpn, input logic [12:0] off,
                      input string req);
    exp_t e;
    @(negedge clk); clr();
    lk_valid = 1; lk_pid = pid; lk_va = {vpn, off};
    e.kind = 0; e.req = req; e.hit = 0; e.pa = '0; e.d = 0; e.r = '0; e.idx = 0;
    for (int i = 0; i < N; i++)
      if (mv[i] && mpid[i] == pid && mvpn[i] == vpn) begin
        e.hit = 1; e.pa = {mppn[i], off}; e.d = md[i]; e.r = mr[i]; mmru = i;
      end
    q.push_back(e);
  endtask

  task automatic vcheck(input string req);
    exp_t e;
    @(negedge clk); clr();
    e.req = req; e.hit = 0; e.pa = '0; e.d = 0; e.r = '0;
    if (low_inv() >= 0) begin e.kind = 1; e.idx = low_inv(); end
    else begin e.kind = 2; e.idx = mmru; end
    q.push_back(e);
  endtask

  task automatic ctrl(input bit do_rf, input logic [7:0] pid, input logic [29:0] vpn,
                      input logic [20:0] ppn, input logic d, input logic [1:0] r,
                      input bit fp_en, input logic [7:0] fp, input bit fall, input string req);
    exp_t e;
    int slot;
    @(negedge clk); clr();
    rf_valid = do_rf; rf_pid = pid; rf_vpn = vpn; rf_ppn = ppn; rf_dirty = d; rf_rights = r;
    flush_pid_en = fp_en; flush_pid = fp; flush_all = fall;
    e.req = req; e.hit = 0; e.pa = '0; e.d = 0; e.r = '0;
    if (low_inv() >= 0) begin e.kind = 1; e.idx = low_inv(); end
    else begin e.kind = 2; e.idx = mmru; end
    q.push_back(e);
    #1;
    slot = (low_inv() >= 0) ? low_inv() : int'(victim_idx);
    if (fall) begin
      for (int i = 0; i < N; i++) mv[i] = 0;
    end else begin
      if (fp_en) for (int i = 0; i < N; i++) if (mpid[i] == fp) mv[i] = 0;
      if (do_rf) begin
        mv[slot] = 1; mpid[slot] = pid; mvpn[slot] = vpn; mppn[slot] = ppn;
        md[slot] = d; mr[slot] = r; mmru = slot;
      end
    end
  endtask

  task automatic refill(input logic [7:0] pid, input logic [29:0] vpn, input logic [20:0] ppn,
                        input logic d, input logic [1:0] r, input string req);
    ctrl(1, pid, vpn, ppn, d, r, 0, 8'h0, 0, req);
  endtask

  initial begin
    forever begin
      @(negedge clk); #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        compared++;
        if (e.kind == 0) begin
          if (lk_hit !== e.hit || (e.hit && (lk_pa !== e.pa || lk_dirty !== e.d || lk_rights !== e.r))) begin
            mismatched++;
            $display("FAIL %s lookup: hit=%0b pa=%h d=%0b r=%0d expected hit=%0b pa=%h d=%0b r=%0d",
                     e.req, lk_hit, lk_pa, lk_dirty, lk_rights, e.hit, e.pa, e.d, e.r);
          end
        end else if (e.kind == 1) begin
          if (int'(victim_idx) != e.idx) begin
            mismatched++;
            $display("FAIL %s victim: got %0d expected %0d", e.req, victim_idx, e.idx);
          end
        end else begin
          if (int'(victim_idx) == e.idx) begin
            mismatched++;
            $display("FAIL %s victim: got %0d expected anything but most recent %0d",
                     e.req, victim_idx, e.idx);
          end
        end
      end
    end
  end

  initial begin
    #800000;
    mismatched++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin mv[i] = 0; mpid[i] = 0; mvpn[i] = 0; mppn[i] = 0; md[i] = 0; mr[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    look(8'd1, 30'h123, 13'h0, "R1");
    vcheck("R1");
    // R2 R4 R5: first refill lands in slot 0
    refill(8'd1, 30'h2_0000, 21'h1_2345, 1, 2'b10, "R5");
    vcheck("R5");
    look(8'd1, 30'h2_0000, 13'h1ABC, "R2");
    look(8'd1, 30'h2_0000, 13'h0007, "R4");
    look(8'd1, 30'h2_0001, 13'h0007, "R2");
    // R3: same page number, other process
    look(8'd2, 30'h2_0000, 13'h0100, "R3");
    refill(8'd2, 30'h2_0000, 21'h0_0F0F, 0, 2'b01, "R5");
    look(8'd2, 30'h2_0000, 13'h0100, "R3");
    look(8'd1, 30'h2_0000, 13'h0100, "R3");
    // R5: fill remaining slots in order
    for (int i = 2; i < N; i++) refill(8'd3, 30'(i), 21'(32'h100 + i), i[0], 2'(i), "R5");
    look(8'd3, 30'd17, 13'h1FFF, "R2");
    // R6: victim avoids the most recent hit
    look(8'd3, 30'd5, 13'h0, "R6");
    repeat (60) vcheck("R6");
    refill(8'd4, 30'h3_3333, 21'h1_5555, 1, 2'b11, "R6");
    repeat (30) vcheck("R6");
    look(8'd4, 30'h3_3333, 13'h0ABC, "R6");
    refill(8'd4, 30'h3_4444, 21'h0_0777, 0, 2'b00, "R6");
    repeat (10) vcheck("R6");
    // R8: flush process 3 only
    ctrl(0, 8'd0, 30'd0, 21'd0, 0, 2'b0, 1, 8'd3, 0, "R8");
    look(8'd3, 30'd17, 13'h0, "R8");
    look(8'd3, 30'd9, 13'h0, "R8");
    look(8'd1, 30'h2_0000, 13'h0055, "R8");
    look(8'd2, 30'h2_0000, 13'h0055, "R8");
    look(8'd4, 30'h3_4444, 13'h0055, "R8");
    vcheck("R5");
    // R9: refill of process 2 survives same-cycle flush of process 2
    ctrl(1, 8'd2, 30'h7_0000, 21'h0_1111, 1, 2'b10, 1, 8'd2, 0, "R9");
    look(8'd2, 30'h7_0000, 13'h0042, "R9");
    look(8'd2, 30'h2_0000, 13'h0042, "R9");
    look(8'd1, 30'h2_0000, 13'h0042, "R9");
    // R7: full flush discards same-cycle refill
    ctrl(1, 8'd5, 30'h5_5555, 21'h0_0ABC, 0, 2'b01, 0, 8'd0, 1, "R7");
    look(8'd5, 30'h5_5555, 13'h0, "R7");
    look(8'd1, 30'h2_0000, 13'h0, "R7");
    look(8'd4, 30'h3_3333, 13'h0, "R7");
    vcheck("R7");
    repeat (4) begin @(negedge clk); clr(); end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule